// File: doc/BRIEF.md
# Radio Channel Retune Sequencer

This block moves a radio onto a new channel in a fixed and safe order. When it accepts a start request it takes in an 8-bit channel number and a band-select flag. It then reads the channel code word that currently sits at one shared-memory location. Next it writes the new code word to that location, so that any agent reading the location sees the target channel before tuning starts. Only after that does it ask the PHY tuning engine to retune, using a request/acknowledge handshake.

If the PHY acknowledges cleanly, the sequencer waits a settle period that is set by a parameter in clock cycles, and then pulses `done`. If the PHY reports a tuning error, the sequencer writes the saved old code word back to the shared location and pulses `error`. The shared memory is single-ported and returns read data one cycle after a read strobe. The sequencer makes at most one memory access per cycle.

Top module: `chan_retune_seq`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `done`, `error`, `tuneReq`, `shmRe` and `shmWe` are all low.
- R2: A `startReq` seen while idle latches `chanNum` and `bandHi`. It raises `busy` in the next cycle, and that same cycle is a read strobe (`shmRe`) to address `CODE_ADDR`.
- R3: The cycle after the read is a write of the new code word. Bits [7:0] hold the channel number, bit 8 is 1 exactly when `bandHi` was 1, and bit 9 (the wide-channel flag) and bits [15:10] are 0. This write comes before `tuneReq` rises.
- R4: `tuneReq` rises in the cycle after the new word is written. It stays high until a cycle in which `tuneAck` or `tuneErr` is sampled high, and it is low in the following cycle.
- R5: When `tuneErr` is sampled, the next cycle writes back the word that was read in the R2 read. The cycle after that pulses `error` and does not pulse `done`.
- R6: When `tuneAck` is sampled without `tuneErr`, `done` pulses exactly `SETTLE_CYC + 1` cycles later. `tuneReq` and the memory strobes stay low in between.
- R7: `done` and `error` are single-cycle pulses. `busy` is high from the read cycle through the pulse cycle, and low in the cycle after the pulse.
- R8: A `startReq` that arrives while `busy` is high is ignored. The code word that is written is still the one latched at the accepted start.
- R9: If `tuneAck` and `tuneErr` are high in the same cycle, the error path is taken.
- R10: `shmRe` and `shmWe` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to retune; acted on only while idle |
| chanNum | input | 8 | Target channel number |
| bandHi | input | 1 | 1 selects the upper (5 GHz) band |
| tuneAck | input | 1 | PHY reports tuning finished |
| tuneErr | input | 1 | PHY reports tuning failed |
| tuneReq | output | 1 | Request to the PHY to retune |
| shmAddr | output | 8 | Address of the channel code word |
| shmRe | output | 1 | Read strobe; data valid on `shmRdata` next cycle |
| shmWe | output | 1 | Write strobe |
| shmWdata | output | 16 | Write data |
| shmRdata | input | 16 | Read data, one cycle after `shmRe` |
| busy | output | 1 | A retune is in progress |
| done | output | 1 | One-cycle pulse: retune finished and settled |
| error | output | 1 | One-cycle pulse: retune failed and old word restored |

## Verification
The bench builds the sequencer with `SETTLE_CYC` set to 20 instead of a full settle time counted in milliseconds. This keeps the wait after an acknowledge short enough to step through every count while still covering the counter's start and terminal cycles. At that value, several back-to-back retunes fit in a short run: clean acknowledges after different PHY delays, errors, the same-cycle acknowledge-and-error case, and a start request made mid-sequence. Each retune is checked against the state of a modelled shared word that carries over from one retune to the next, so the restore path is tested against a value that the previous retune wrote.

// File: rtl/chan_retune_pkg.sv
package chan_retune_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_READ_OLD, S_WRITE_NEW, S_TUNE_WAIT, S_SETTLE, S_RESTORE, S_FINISH
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // capture channel and band
    logic saveOld;    // capture read data as the rollback word
    logic clrCnt;     // restart settle count
    logic incCnt;     // advance settle count
    logic selRestore; // write data selects the rollback word
  } dpCtl_t;

  localparam int BAND_BIT = 8;
  localparam int WIDE_BIT = 9;
endpackage

// File: rtl/chan_retune_dp.sv
module chan_retune_dp
  import chan_retune_pkg::*;
#(
  parameter int CHAN_W     = 8,
  parameter int WORD_W     = 16,
  parameter int SETTLE_CYC = 1600000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [CHAN_W-1:0] chanNum,
  input  logic              bandHi,
  input  logic [WORD_W-1:0] shmRdata,
  output logic [WORD_W-1:0] shmWdata,
  output logic              settleLast
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  logic [WORD_W-1:0] newWord, savedWord, builtWord;
  logic [CNT_W-1:0]  settleCnt;

  // New code word: channel low, band flag above it, wide flag left clear
  always_comb begin
    builtWord = '0;
    builtWord[CHAN_W-1:0] = chanNum;
    builtWord[BAND_BIT]   = bandHi;
    builtWord[WIDE_BIT]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newWord   <= '0;
      savedWord <= '0;
      settleCnt <= '0;
    end else begin
      if (ctl.latchReq) newWord   <= builtWord;
      if (ctl.saveOld)  savedWord <= shmRdata;
      if (ctl.clrCnt)      settleCnt <= '0;
      else if (ctl.incCnt) settleCnt <= settleCnt + 1'b1;
    end
  end

  assign shmWdata   = ctl.selRestore ? savedWord : newWord;
  assign settleLast = (settleCnt == CNT_W'(SETTLE_CYC - 1));
endmodule

// File: rtl/chan_retune_ctrl.sv
module chan_retune_ctrl
  import chan_retune_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   tuneAck,
  input  logic   tuneErr,
  input  logic   settleLast,
  output dpCtl_t ctl,
  output logic   tuneReq,
  output logic   shmRe,
  output logic   shmWe,
  output logic   busy,
  output logic   done,
  output logic   error
);
  seqState_t state, nextState;
  logic      failFlag;

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      S_IDLE: if (startReq) begin
        nextState    = S_READ_OLD;
        ctl.latchReq = 1'b1;
      end
      S_READ_OLD:  nextState = S_WRITE_NEW;
      S_WRITE_NEW: begin
        nextState   = S_TUNE_WAIT;
        ctl.saveOld = 1'b1;
      end
      S_TUNE_WAIT: begin
        if (tuneErr) nextState = S_RESTORE;           // error wins
        else if (tuneAck) begin
          nextState  = S_SETTLE;
          ctl.clrCnt = 1'b1;
        end
      end
      S_SETTLE: begin
        ctl.incCnt = 1'b1;
        if (settleLast) nextState = S_FINISH;
      end
      S_RESTORE: begin
        nextState      = S_FINISH;
        ctl.selRestore = 1'b1;
      end
      S_FINISH: nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      failFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE) failFlag <= 1'b0;
      else if (state == S_TUNE_WAIT && tuneErr) failFlag <= 1'b1;
    end
  end

  assign shmRe   = (state == S_READ_OLD);
  assign shmWe   = (state == S_WRITE_NEW) || (state == S_RESTORE);
  assign tuneReq = (state == S_TUNE_WAIT);
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_FINISH) && !failFlag;
  assign error   = (state == S_FINISH) && failFlag;
endmodule

// File: rtl/chan_retune_seq.sv
module chan_retune_seq
  import chan_retune_pkg::*;
#(
  parameter int CHAN_W     = 8,
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 8,
  parameter int CODE_ADDR  = 8'h40,
  parameter int SETTLE_CYC = 1600000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [CHAN_W-1:0] chanNum,
  input  logic              bandHi,
  input  logic              tuneAck,
  input  logic              tuneErr,
  output logic              tuneReq,
  output logic [ADDR_W-1:0] shmAddr,
  output logic              shmRe,
  output logic              shmWe,
  output logic [WORD_W-1:0] shmWdata,
  input  logic [WORD_W-1:0] shmRdata,
  output logic              busy,
  output logic              done,
  output logic              error
);
  dpCtl_t ctl;
  logic   settleLast;

  assign shmAddr = ADDR_W'(CODE_ADDR);

  chan_retune_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .tuneAck(tuneAck),
    .tuneErr(tuneErr), .settleLast(settleLast), .ctl(ctl), .tuneReq(tuneReq),
    .shmRe(shmRe), .shmWe(shmWe), .busy(busy), .done(done), .error(error)
  );

  chan_retune_dp #(.CHAN_W(CHAN_W), .WORD_W(WORD_W), .SETTLE_CYC(SETTLE_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .chanNum(chanNum), .bandHi(bandHi),
    .shmRdata(shmRdata), .shmWdata(shmWdata), .settleLast(settleLast)
  );
endmodule

// File: rtl/chan_retune_chk.sv
module chan_retune_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              tuneAck,
  input logic              tuneErr,
  input logic              tuneReq,
  input logic              shmRe,
  input logic              shmWe,
  input logic [WORD_W-1:0] shmWdata,
  input logic              busy,
  input logic              done,
  input logic              error
);
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(shmRe && shmWe)); // R10
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> (busy && shmRe)); // R2
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    shmRe |=> (shmWe && !shmWdata[9] && !tuneReq)); // R3
  AST_TUNE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (tuneReq && !tuneAck && !tuneErr) |=> tuneReq); // R4
  AST_TUNE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (tuneReq && (tuneAck || tuneErr)) |=> !tuneReq); // R4
  AST_ERR_AFTER_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    error |-> $past(shmWe)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (done || error) |=> (!done && !error && !busy)); // R7
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error)); // R5
  AST_ERR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (tuneReq && tuneErr) |=> shmWe); // R9
endmodule

bind chan_retune_seq chan_retune_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .tuneAck(tuneAck),
  .tuneErr(tuneErr), .tuneReq(tuneReq), .shmRe(shmRe), .shmWe(shmWe),
  .shmWdata(shmWdata), .busy(busy), .done(done), .error(error)
);

// File: tb/chan_retune_seq_bench.sv
module chan_retune_seq_bench;
  localparam int SETTLE = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [7:0]  chanNum = '0;
  logic        bandHi = 1'b0;
  logic        tuneAck = 1'b0;
  logic        tuneErr = 1'b0;
  logic        tuneReq, shmRe, shmWe, busy, done, error;
  logic [7:0]  shmAddr;
  logic [15:0] shmWdata;
  logic [15:0] shmRdata;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  chan_retune_seq #(.SETTLE_CYC(SETTLE)) u_chan_retune_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chanNum(chanNum),
    .bandHi(bandHi), .tuneAck(tuneAck), .tuneErr(tuneErr), .tuneReq(tuneReq),
    .shmAddr(shmAddr), .shmRe(shmRe), .shmWe(shmWe), .shmWdata(shmWdata),
    .shmRdata(shmRdata), .busy(busy), .done(done), .error(error)
  );

  // Shared memory: the one code word location, read data one cycle late
  logic [15:0] mem = 16'h1234;
  always_ff @(posedge clk) begin
    if (shmWe && shmAddr == 8'h40) mem <= shmWdata;
    if (shmRe) shmRdata <= mem;
  end

  // Reference model: phase 0 idle,1 read,2 write,3 tune,4 settle,5 restore,6 report
  int          mPh = 0;
  int          mCnt = 0;
  bit          mErr = 0;
  logic [15:0] mNew = '0, mSaved = '0, mMem = 16'h1234;

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mErr = 0;
    end else begin
      case (mPh)
        0: if (startReq) begin
             mNew = {7'b0, bandHi, chanNum}; mErr = 0; mPh = 1;
           end
        1: begin mSaved = mMem; mPh = 2; end
        2: begin mMem = mNew; mPh = 3; end
        3: if (tuneErr) begin mErr = 1; mPh = 5; end
           else if (tuneAck) begin mCnt = SETTLE; mPh = 4; end
        4: begin mCnt--; if (mCnt == 0) mPh = 6; end
        5: begin mMem = mSaved; mPh = 6; end
        default: mPh = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      check(!busy && !done && !error && !tuneReq && !shmRe && !shmWe, "R1",
            "reset outputs", {10'b0, busy, done, error, tuneReq, shmRe, shmWe}, 16'h0);
    end else begin
      check(busy == (mPh != 0), "R7", "busy", 16'(busy), 16'(mPh != 0));
      check(shmRe == (mPh == 1), "R2", "read strobe", 16'(shmRe), 16'(mPh == 1));
      check(shmWe == (mPh == 2 || mPh == 5), (mPh == 5) ? "R5" : "R3", "write strobe",
            16'(shmWe), 16'(mPh == 2 || mPh == 5));
      if (mPh == 2) check(shmWdata == mNew, "R3", "new code word", shmWdata, mNew);
      if (mPh == 5) check(shmWdata == mSaved, "R5", "restored word", shmWdata, mSaved);
      check(tuneReq == (mPh == 3), "R4", "tune request", 16'(tuneReq), 16'(mPh == 3));
      check(done == (mPh == 6 && !mErr), "R6", "done pulse", 16'(done), 16'(mPh == 6 && !mErr));
      check(error == (mPh == 6 && mErr), "R5", "error pulse", 16'(error), 16'(mPh == 6 && mErr));
      check(!(shmRe && shmWe), "R10", "single access", {14'b0, shmRe, shmWe}, 16'h0);
    end
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // One retune; resp 0 = ack, 1 = err, 2 = both in one cycle
  task automatic retune(input logic [7:0] ch, input bit hi, input int resp,
                        input int delay, input bit poke);
    startReq = 1'b1; chanNum = ch; bandHi = hi;
    @(negedge clk);
    startReq = 1'b0;
    if (poke) begin  // R8: start while busy must be ignored
      @(negedge clk);
      startReq = 1'b1; chanNum = 8'd1; bandHi = 1'b0;
      @(negedge clk);
      startReq = 1'b0;
    end
    while (!tuneReq) @(negedge clk);
    repeat (delay) @(negedge clk);
    tuneAck = (resp != 1);
    tuneErr = (resp != 0);
    @(negedge clk);
    tuneAck = 1'b0; tuneErr = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    retune(8'd6, 1'b0, 0, 0, 1'b0);
    check(mem == 16'h0006, "R6", "word after clean retune", mem, 16'h0006);
    retune(8'd149, 1'b1, 0, 3, 1'b1);
    check(mem == 16'h0195, "R8", "word after ignored start", mem, 16'h0195);
    retune(8'd36, 1'b1, 1, 2, 1'b0);
    check(mem == 16'h0195, "R5", "word rolled back", mem, 16'h0195);
    retune(8'd255, 1'b0, 2, 0, 1'b0);
    check(mem == 16'h0195, "R9", "both responses take error path", mem, 16'h0195);
    retune(8'd0, 1'b0, 0, 5, 1'b0);
    check(mem == 16'h0000, "R3", "channel zero word", mem, 16'h0000);
    retune(8'd200, 1'b1, 0, 1, 1'b0);
    check(mem == 16'h01C8, "R3", "upper band word", mem, 16'h01C8);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule